// File: doc/BRIEF.md
# Thermal Alarm Output Controller

This block turns a stream of temperature samples into a thermal alarm. Each time the converter finishes, it presents a 9-bit signed sample with a one-cycle strobe. The block compares that sample against a programmable trip level and a programmable release level. It then decides whether the alarm output changes. The surrounding register file supplies the trip level, the release level and a 5-bit configuration word. The bus interface sends a one-cycle pulse whenever any register is read.

There are two output behaviours. In thermostat mode the alarm follows the temperature with hysteresis. In latched-event mode an excursion raises the alarm, and it stays raised until the next bus read. After each read the block re-arms on the opposite threshold. A consecutive-sample filter of 1, 2, 4 or 6 samples qualifies every change. A polarity bit sets whether the open-drain pad is pulled low on an active alarm or on an inactive one. A shutdown bit stops samples from being taken.

The package also holds the power-up threshold values for the register file: trip 80 °C (0x0A0) and release 75 °C (0x096). Power-up mode is thermostat mode.

Top module: `thermal_alarm_ctrl`

## Requirements
- R1: All values are 9-bit two's complement at 0.5 °C per LSB, and every comparison is signed. In thermostat mode with the alarm inactive, a qualifying sample strictly greater than the trip level raises the alarm on the clock edge that takes the sample. A sample equal to the trip level does not raise it.
- R2: In thermostat mode with the alarm active, a qualifying sample strictly below the release level clears the alarm. Samples equal to or above the release level keep it active.
- R3: In latched-event mode (cfg_bits[1]=1), a raised alarm stays raised regardless of later samples until a bus_read pulse clears it. When a read and an event-completing sample arrive in the same cycle, the alarm is left raised.
- R4: In latched-event mode the block waits for one threshold at a time. After a high event (sample above the trip level) it waits for a low event (sample below the release level), and the reverse. While it waits for one threshold, crossings of the other are ignored. A low event is also cleared by a bus read.
- R5: cfg_bits[4:3] sets how many consecutive qualifying samples are needed before the output changes: 00 gives 1, 01 gives 2, 10 gives 4, 11 gives 6. A sample that does not qualify restarts the count.
- R6: pad_pull_low is 1 when the alarm is active and cfg_bits[2]=0 (active-low pin). It is also 1 when the alarm is inactive and cfg_bits[2]=1 (active-high pin). Otherwise it is 0 and the pin is released.
- R7: While cfg_bits[0]=1 (shutdown), samples are ignored. Entering shutdown in latched-event mode clears the alarm. In thermostat mode the alarm is held through shutdown.
- R8: In thermostat mode bus_read has no effect on the alarm.
- R9: A change of the trip level, release level, mode or filter length restarts the consecutive-sample count.
- R10: After reset the alarm is inactive, the count is zero and latched-event mode waits for a high event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | One-cycle strobe: a new sample is present |
| sample_temp | input | 9 | Signed temperature sample, 0.5 °C per LSB |
| setpoint | input | 9 | Signed trip level |
| hysteresis | input | 9 | Signed release level |
| cfg_bits | input | 5 | [0] shutdown, [1] latched-event mode, [2] active-high pin, [4:3] filter length code |
| bus_read | input | 1 | One-cycle pulse: a register was read |
| alarm_active | output | 1 | Logical alarm state |
| pad_pull_low | output | 1 | Open-drain enable: 1 pulls the pin low |

## Verification
The properties assume the configuration and thresholds come from a register file, and that sample_valid and bus_read are single-cycle pulses from neighbouring blocks. The trip-on-sample property also assumes the configuration and thresholds were stable in the cycle before the sample, because a change in that cycle restarts the filter. The stimulus keeps to these assumptions: every configuration or threshold change is applied in an idle cycle, one clock before the sample that uses it. Only one directed case combines a read with an event-completing sample in the same cycle.

// File: rtl/thalarm_pkg.sv
package thalarm_pkg;

   // configuration word layout, LSB first: shutdown, latched mode, pin polarity, filter code
   typedef struct packed {
      logic [1:0] qsel;
      logic       pol_high;
      logic       latched;
      logic       shdn;
   } cfg_t;

   localparam int CFG_W = 5;

   // power-up values for the register file that feeds this block
   localparam logic [8:0] PWRUP_TRIP    = 9'h0A0;
   localparam logic [8:0] PWRUP_RELEASE = 9'h096;

   localparam int QLEN_MAX = 6;

   function automatic int unsigned q_len(input logic [1:0] code);
      case (code)
         2'b00:   return 1;
         2'b01:   return 2;
         2'b10:   return 4;
         default: return QLEN_MAX;
      endcase
   endfunction

endpackage

// File: rtl/ta_cfg_watch.sv
module ta_cfg_watch #(
   parameter int TEMP_W = 9
) (
   input  logic              clk,
   input  logic [TEMP_W-1:0] trip_lvl,
   input  logic [TEMP_W-1:0] rel_lvl,
   input  logic [1:0]        qsel,
   input  logic              latched,
   output logic              changed
);
   localparam int SNAP_W = 2 * TEMP_W + 3;

   logic [SNAP_W-1:0] snap_now;
   logic [SNAP_W-1:0] snap_prev;

   assign snap_now = {trip_lvl, rel_lvl, qsel, latched};

   // free-running shadow: it tracks the inputs through reset so nothing is flagged afterwards
   always_ff @(posedge clk) begin
      snap_prev <= snap_now;
   end

   assign changed = (snap_now != snap_prev);

endmodule

// File: rtl/ta_thresh_cmp.sv
module ta_thresh_cmp #(
   parameter int TEMP_W = 9
) (
   input  logic [TEMP_W-1:0] temp,
   input  logic [TEMP_W-1:0] trip_lvl,
   input  logic [TEMP_W-1:0] rel_lvl,
   input  logic              look_low,
   output logic              hit
);
   logic above_trip;
   logic below_rel;

   assign above_trip = ($signed(temp) > $signed(trip_lvl));
   assign below_rel  = ($signed(temp) < $signed(rel_lvl));
   assign hit        = look_low ? below_rel : above_trip;

endmodule

// File: rtl/ta_fault_q.sv
module ta_fault_q #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             sample_en,
   input  logic             hit,
   input  logic [CNT_W-1:0] need,
   output logic             fire
);
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_nxt;

   assign cnt_nxt = cnt + 1'b1;
   assign fire    = sample_en && hit && !clear && (cnt_nxt == need);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clear) begin
         cnt <= '0;
      end else if (sample_en) begin
         if (!hit || fire) cnt <= '0;
         else              cnt <= cnt_nxt;
      end
   end

endmodule

// File: rtl/ta_alarm_fsm.sv
module ta_alarm_fsm (
   input  logic clk,
   input  logic rst_n,
   input  logic latched,
   input  logic shdn,
   input  logic fire,
   input  logic bus_read,
   output logic alarm,
   output logic look_low
);
   logic wait_low;
   logic shdn_q;
   logic enter_sd;

   assign enter_sd = shdn && !shdn_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         alarm    <= 1'b0;
         wait_low <= 1'b0;
         shdn_q   <= 1'b0;
      end else begin
         shdn_q <= shdn;
         if (latched) begin
            if (enter_sd) begin
               alarm <= 1'b0;
            end else if (fire) begin
               alarm    <= 1'b1;
               wait_low <= !wait_low;
            end else if (bus_read) begin
               alarm <= 1'b0;
            end
         end else if (fire) begin
            alarm <= !alarm;
         end
      end
   end

   assign look_low = latched ? wait_low : alarm;

endmodule

// File: rtl/thermal_alarm_ctrl.sv
module thermal_alarm_ctrl #(
   parameter int TEMP_W  = 9,
   parameter int CNT_W   = 3,
   parameter bit PAD_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample_valid,
   input  logic [TEMP_W-1:0] sample_temp,
   input  logic [TEMP_W-1:0] setpoint,
   input  logic [TEMP_W-1:0] hysteresis,
   input  logic [4:0]        cfg_bits,
   input  logic              bus_read,
   output logic              alarm_active,
   output logic              pad_pull_low
);
   import thalarm_pkg::*;

   localparam int CNT_MAX = (1 << CNT_W) - 1;

   if (TEMP_W < 2) begin : g_bad_temp_w
      $error("thermal_alarm_ctrl: TEMP_W must be at least 2");
   end
   if (CNT_MAX < QLEN_MAX) begin : g_bad_cnt_w
      $error("thermal_alarm_ctrl: CNT_W too narrow for the longest filter");
   end

   cfg_t             cfg_s;
   logic             changed;
   logic             look_low;
   logic             hit;
   logic             fire;
   logic             alarm;
   logic             sample_en;
   logic             clear;
   logic [CNT_W-1:0] need;

   assign cfg_s     = cfg_t'(cfg_bits);
   assign need      = CNT_W'(q_len(cfg_s.qsel));
   assign sample_en = sample_valid && !cfg_s.shdn && !(cfg_s.latched && alarm);
   assign clear     = changed || cfg_s.shdn || (cfg_s.latched && alarm);

   ta_cfg_watch #(.TEMP_W(TEMP_W)) u_watch (
      .clk      (clk),
      .trip_lvl (setpoint),
      .rel_lvl  (hysteresis),
      .qsel     (cfg_s.qsel),
      .latched  (cfg_s.latched),
      .changed  (changed)
   );

   ta_thresh_cmp #(.TEMP_W(TEMP_W)) u_cmp (
      .temp     (sample_temp),
      .trip_lvl (setpoint),
      .rel_lvl  (hysteresis),
      .look_low (look_low),
      .hit      (hit)
   );

   ta_fault_q #(.CNT_W(CNT_W)) u_fq (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (clear),
      .sample_en (sample_en),
      .hit       (hit),
      .need      (need),
      .fire      (fire)
   );

   ta_alarm_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .latched  (cfg_s.latched),
      .shdn     (cfg_s.shdn),
      .fire     (fire),
      .bus_read (bus_read),
      .alarm    (alarm),
      .look_low (look_low)
   );

   assign alarm_active = alarm;

   if (PAD_REG) begin : g_pad_reg
      logic pad_q;
      always_ff @(posedge clk) begin
         if (!rst_n) pad_q <= 1'b0;
         else        pad_q <= alarm ^ cfg_s.pol_high;
      end
      assign pad_pull_low = pad_q;
   end else begin : g_pad_comb
      assign pad_pull_low = alarm ^ cfg_s.pol_high;
   end

endmodule

// File: rtl/ta_alarm_chk.sv
module ta_alarm_chk #(
   parameter int TEMP_W = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sample_valid,
   input logic [TEMP_W-1:0] sample_temp,
   input logic [TEMP_W-1:0] setpoint,
   input logic [TEMP_W-1:0] hysteresis,
   input logic [4:0]        cfg_bits,
   input logic              bus_read,
   input logic              alarm_active
);
   // R1
   trip_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_valid && !cfg_bits[0] && !cfg_bits[1] && !alarm_active &&
       cfg_bits[4:3] == 2'b00 && $stable(setpoint) && $stable(hysteresis) &&
       $stable(cfg_bits[4:1]) && $signed(sample_temp) > $signed(setpoint))
      |=> alarm_active);

   // R1
   no_trip_at_or_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_bits[1] && !alarm_active &&
       (!sample_valid || $signed(sample_temp) <= $signed(setpoint)))
      |=> !alarm_active);

   // R2
   hold_above_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_bits[1] && alarm_active &&
       (!sample_valid || $signed(sample_temp) >= $signed(hysteresis)))
      |=> alarm_active);

   // R3
   latched_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_bits[1] && !cfg_bits[0] && alarm_active && !bus_read)
      |=> alarm_active);

   // R7
   shutdown_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_bits[1] && $rose(cfg_bits[0])) |=> !alarm_active);

   // R7
   shutdown_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_bits[0] |=> !$rose(alarm_active));

   // R8
   read_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_bits[1] && !sample_valid) |=> $stable(alarm_active));

endmodule

bind thermal_alarm_ctrl ta_alarm_chk #(.TEMP_W(TEMP_W)) u_chk (.*);

// File: tb/tb_thermal_alarm_ctrl.sv
module tb_thermal_alarm_ctrl;

   typedef struct packed {
      logic [4:0] cfg;
      logic [8:0] sp;
      logic [8:0] hy;
      logic [8:0] t;
      logic       v;
      logic       rd;
      logic       ex;
      logic [3:0] req;
   } vec_t;

   localparam logic [8:0] S = 9'h0A0;
   localparam logic [8:0] H = 9'h096;
   localparam int NV = 44;

   localparam vec_t VECS [NV] = '{
      '{5'h00, S, H, 9'h0A0, 1'b1, 1'b0, 1'b0, 4'd1},      // R1 equal to trip: no alarm
      '{5'h00, S, H, 9'h0A1, 1'b1, 1'b0, 1'b1, 4'd1},      // R1 one LSB above
      '{5'h00, S, H, 9'h096, 1'b1, 1'b0, 1'b1, 4'd2},      // R2 equal to release: held
      '{5'h00, S, H, 9'h095, 1'b1, 1'b0, 1'b0, 4'd2},      // R2 below release
      '{5'h00, 9'h1F6, 9'h1EC, 9'h0FA, 1'b1, 1'b0, 1'b1, 4'd1}, // R1 signed compare
      '{5'h00, 9'h1F6, 9'h1EC, 9'h192, 1'b1, 1'b0, 1'b0, 4'd2}, // R2 signed compare
      '{5'h00, 9'h1F6, 9'h1EC, 9'h1F6, 1'b1, 1'b0, 1'b0, 4'd1}, // R1 negative equal
      '{5'h00, S, H, 9'h0B0, 1'b1, 1'b0, 1'b1, 4'd1},      // R1
      '{5'h00, S, H, 9'h000, 1'b0, 1'b1, 1'b1, 4'd8},      // R8 read ignored
      '{5'h04, S, H, 9'h000, 1'b0, 1'b0, 1'b1, 4'd6},      // R6 active-high pin
      '{5'h04, S, H, 9'h050, 1'b1, 1'b0, 1'b0, 4'd6},      // R6 inactive, active-high pin
      '{5'h08, S, H, 9'h0B0, 1'b1, 1'b0, 1'b0, 4'd5},      // R5 len 2, first
      '{5'h08, S, H, 9'h0B0, 1'b1, 1'b0, 1'b1, 4'd5},      // R5 len 2, second
      '{5'h08, S, H, 9'h050, 1'b1, 1'b0, 1'b1, 4'd5},      // R5
      '{5'h08, S, H, 9'h0A0, 1'b1, 1'b0, 1'b1, 4'd5},      // R5 miss restarts
      '{5'h08, S, H, 9'h050, 1'b1, 1'b0, 1'b1, 4'd5},      // R5
      '{5'h08, S, H, 9'h050, 1'b1, 1'b0, 1'b0, 4'd5},      // R5
      '{5'h18, S, H, 9'h0B0, 1'b1, 1'b0, 1'b0, 4'd5},      // R5 len 6
      '{5'h18, S, H, 9'h0B0, 1'b1, 1'b0, 1'b0, 4'd5},
      '{5'h18, S, H, 9'h0B0, 1'b1, 1'b0, 1'b0, 4'd5},
      '{5'h18, S, H, 9'h0B0, 1'b1, 1'b0, 1'b0, 4'd5},
      '{5'h18, S, H, 9'h0B0, 1'b1, 1'b0, 1'b0, 4'd5},
      '{5'h18, S, H, 9'h0B0, 1'b1, 1'b0, 1'b1, 4'd5},      // R5 sixth
      '{5'h10, S, H, 9'h050, 1'b1, 1'b0, 1'b1, 4'd5},      // R5 len 4
      '{5'h10, S, H, 9'h050, 1'b1, 1'b0, 1'b1, 4'd5},
      '{5'h10, S, H, 9'h050, 1'b1, 1'b0, 1'b1, 4'd5},
      '{5'h10, S, H, 9'h050, 1'b1, 1'b0, 1'b0, 4'd5},      // R5 fourth
      '{5'h02, S, H, 9'h0B0, 1'b1, 1'b0, 1'b1, 4'd3},      // R3 high event
      '{5'h02, S, H, 9'h050, 1'b1, 1'b0, 1'b1, 4'd3},      // R3 held after drop
      '{5'h02, S, H, 9'h000, 1'b0, 1'b1, 1'b0, 4'd3},      // R3 read clears
      '{5'h02, S, H, 9'h0B0, 1'b1, 1'b0, 1'b0, 4'd4},      // R4 waits low now
      '{5'h02, S, H, 9'h090, 1'b1, 1'b0, 1'b1, 4'd4},      // R4 low event
      '{5'h02, S, H, 9'h000, 1'b0, 1'b1, 1'b0, 4'd4},      // R4 read clears low event
      '{5'h02, S, H, 9'h050, 1'b1, 1'b0, 1'b0, 4'd4},      // R4 waits high
      '{5'h02, S, H, 9'h0B0, 1'b1, 1'b0, 1'b1, 4'd4},      // R4
      '{5'h03, S, H, 9'h000, 1'b0, 1'b0, 1'b0, 4'd7},      // R7 entering shutdown clears
      '{5'h03, S, H, 9'h050, 1'b1, 1'b0, 1'b0, 4'd7},      // R7 sample ignored
      '{5'h00, S, H, 9'h0B0, 1'b1, 1'b0, 1'b1, 4'd1},      // R1
      '{5'h01, S, H, 9'h000, 1'b0, 1'b0, 1'b1, 4'd7},      // R7 thermostat held
      '{5'h01, S, H, 9'h050, 1'b1, 1'b0, 1'b1, 4'd7},      // R7 sample ignored
      '{5'h00, S, H, 9'h050, 1'b1, 1'b0, 1'b0, 4'd2},      // R2
      '{5'h08, S, H, 9'h0B0, 1'b1, 1'b0, 1'b0, 4'd9},      // R9 first of two
      '{5'h08, 9'h0A1, H, 9'h0B0, 1'b1, 1'b0, 1'b0, 4'd9}, // R9 trip change restarts
      '{5'h08, 9'h0A1, H, 9'h0B0, 1'b1, 1'b0, 1'b1, 4'd9}  // R9
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sample_valid = 1'b0;
   logic [8:0] sample_temp = '0;
   logic [8:0] setpoint = S;
   logic [8:0] hysteresis = H;
   logic [4:0] cfg_bits = '0;
   logic       bus_read = 1'b0;
   logic       alarm_active;
   logic       pad_pull_low;

   int errors = 0;
   int checks = 0;
   bit ended  = 1'b0;

   always #2 clk = !clk;

   thermal_alarm_ctrl dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .sample_valid (sample_valid),
      .sample_temp  (sample_temp),
      .setpoint     (setpoint),
      .hysteresis   (hysteresis),
      .cfg_bits     (cfg_bits),
      .bus_read     (bus_read),
      .alarm_active (alarm_active),
      .pad_pull_low (pad_pull_low)
   );

   task automatic check_bit(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   // apply settings in an idle cycle, then the sample/read cycle, then check
   task automatic step(input logic [4:0] c, input logic [8:0] sp, input logic [8:0] hy,
                       input logic [8:0] t, input logic v, input logic rd,
                       input logic ex, input string tag);
      @(negedge clk);
      cfg_bits = c; setpoint = sp; hysteresis = hy; sample_valid = 1'b0; bus_read = 1'b0;
      @(negedge clk);
      sample_temp = t; sample_valid = v; bus_read = rd;
      @(negedge clk);
      sample_valid = 1'b0; bus_read = 1'b0;
      check_bit({tag, " alarm"}, alarm_active, ex);
      // R6 pin pulled low for active alarm on active-low pin, or idle alarm on active-high pin
      check_bit({tag, " pad R6"}, pad_pull_low, c[2] ? !ex : ex);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      check_bit("R10 reset alarm", alarm_active, 1'b0);
      check_bit("R10 reset pad", pad_pull_low, 1'b0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         step(VECS[i].cfg, VECS[i].sp, VECS[i].hy, VECS[i].t, VECS[i].v, VECS[i].rd,
              VECS[i].ex, $sformatf("row %0d R%0d", i, VECS[i].req));
      end

      // R10 reset mid-run: alarm active before, latched mode left waiting low earlier
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check_bit("R10 mid-run reset alarm", alarm_active, 1'b0);
      rst_n = 1'b1;
      step(5'h02, S, H, 9'h050, 1'b1, 1'b0, 1'b0, "R10 waits high after reset");
      step(5'h02, S, H, 9'h0B0, 1'b1, 1'b0, 1'b1, "R10 high event after reset");
      step(5'h02, S, H, 9'h000, 1'b0, 1'b1, 1'b0, "R3 read clears");
      // R3 read in the same cycle as a completing low event: alarm stays raised
      step(5'h02, S, H, 9'h050, 1'b1, 1'b1, 1'b1, "R3 read with event");
      // R4 crossing of the wrong threshold while waiting: after read, waiting high
      step(5'h02, S, H, 9'h000, 1'b0, 1'b1, 1'b0, "R4 read clears");
      step(5'h02, S, H, 9'h050, 1'b1, 1'b0, 1'b0, "R4 low ignored while waiting high");

      finish_run();
   end

endmodule